// File: doc/BRIEF.md
# Interleaved Multiphase PWM Sequencer

This block times the switch-node commands of a buck converter built from one to three interleaved phases. One shared counter runs from zero to the programmed period minus one and serves as the sawtooth for every phase. Each phase sees that counter shifted by its own stagger, so the phases turn off at evenly spaced points of the period. At its turn-off point a phase goes low. It stays low for a forced off-time of one third of a period, which leaves room for a current sample. It then turns on once its ramp meets the control-loop command less that phase's balance correction, and it stays on until its next turn-off point.

Each phase also drives a current-sample window. The window opens one sixth of a period after the turn-off and closes when the phase next turns on. A sense value is tracked while the window is open and is held from the close of one window until the close of the next. The period and the phase-presence flags are taken at reset and at the end of every period, so a new setting always starts on a clean cycle boundary.

Top module: `mpwm_seq`

## Requirements
- R1: While `rst` is high, every bit of `pwmOut` and `sampleWin` is low. The first clock edge with `rst` high clears every `heldSense` lane to zero, and the next cycle is count zero of a period.
- R2: The period P equals `periodLen`, or 6 when `periodLen` is below 6. The shared count runs 0..P-1 and wraps. `periodLen` and `phasePresent` are taken at the reset edge and at the edge that ends count P-1. Phase 1 is low at count zero, and its falling edges are P cycles apart.
- R3: Three-phase mode uses T = floor(P/3). Phase 2 turns off T cycles after phase 1, and phase 3 turns off T cycles after phase 2.
- R4: Two-phase mode uses H = floor(P/2). Phase 2 turns off H cycles after phase 1.
- R5: With `phasePresent[0]` (phase 2 present) low, only phase 1 runs. With `phasePresent[0]` high and `phasePresent[1]` (phase 3 present) low, phases 1 and 2 run. With both bits high, all three run. An inactive phase keeps its `pwmOut` and `sampleWin` bits low.
- R6: A phase's ramp is (count - its stagger) mod P, where phase 1 has stagger 0. The phase is low whenever its ramp is below T, whatever the command.
- R7: Let the phase threshold be `loopCmd - phaseCorr[k]`, or 0 when that difference would be negative. With ramp ≥ T, the phase is high when it was high in the previous cycle or when ramp + threshold ≥ P. It therefore turns on when ramp + threshold first reaches P and stays on until its ramp returns to 0.
- R8: An active phase's `sampleWin` bit is high exactly when its ramp is at least floor(P/6) and its `pwmOut` bit is low.
- R9: At each clock edge with the window open, the phase's tracker takes `senseIn[k]`. At the first edge after a window closes, `heldSense[k]` takes the tracker's value. At every other edge `heldSense[k]` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| periodLen | input | CNT_W | Switching period in clock cycles |
| phasePresent | input | 2 | Bit 0: phase 2 present; bit 1: phase 3 present |
| loopCmd | input | CNT_W | Control-loop command shared by all phases |
| phaseCorr | input | 3 × CNT_W | Per-phase balance correction, subtracted from the command |
| senseIn | input | 3 × SENSE_W | Per-phase sensed current |
| pwmOut | output | 3 | Per-phase PWM command, bit k is phase k+1 |
| sampleWin | output | 3 | Per-phase current-sample window |
| heldSense | output | 3 × SENSE_W | Per-phase sense value captured at window close |

## Verification
The bench builds the block with CNT_W = 10, SENSE_W = 8 and MIN_PERIOD = 6. Random periods between 3 and 70 then cover the clamp below six, periods that 3 and 6 do not divide evenly (where truncation moves the stagger and the window start), and commands both above and below the period. Periods and presence flags also change without a reset, which exercises a new setting taking effect at the wrap while a phase is still latched high. Directed runs measure the gaps between falling edges, the duty and the window length at the ports in all three modes.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;
  localparam int NPH = 3;

  typedef enum logic [1:0] {
    MODE_ONE   = 2'd0,
    MODE_TWO   = 2'd1,
    MODE_THREE = 2'd2
  } phMode_e;

  typedef struct packed {
    logic           run;
    logic           fresh;
    logic [NPH-1:0] act;
  } seqStrobe_t;
endpackage

// File: rtl/mpwm_ctrl.sv
module mpwm_ctrl
  import mpwm_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int MIN_PERIOD = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [CNT_W-1:0]          periodLen,
  input  logic [1:0]                phasePresent,
  output logic [CNT_W-1:0]          cnt,
  output logic [CNT_W-1:0]          perQ,
  output logic [CNT_W-1:0]          thirdQ,
  output logic [CNT_W-1:0]          sixthQ,
  output logic [NPH-1:0][CNT_W-1:0] phaseOff,
  output seqStrobe_t                strobe
);
  localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

  logic [CNT_W-1:0] halfQ;
  logic [CNT_W-1:0] pEff;
  phMode_e          modeQ;
  phMode_e          modeNext;
  logic             wrap;
  logic             loadNow;

  assign pEff    = (periodLen < MIN_P) ? MIN_P : periodLen;
  assign wrap    = (cnt == perQ - 1'b1);
  assign loadNow = rst || wrap;

  always_comb begin
    if (!phasePresent[0])      modeNext = MODE_ONE;
    else if (!phasePresent[1]) modeNext = MODE_TWO;
    else                       modeNext = MODE_THREE;
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (loadNow) begin
      perQ   <= pEff;
      thirdQ <= pEff / CNT_W'(3);
      halfQ  <= pEff >> 1;
      sixthQ <= pEff / CNT_W'(6);
      modeQ  <= modeNext;
    end
  end

  always_comb begin
    phaseOff[0] = '0;
    phaseOff[1] = (modeQ == MODE_THREE) ? thirdQ : halfQ;
    phaseOff[2] = thirdQ << 1;
  end

  always_comb begin
    strobe.run    = !rst;
    strobe.fresh  = (cnt == '0);
    strobe.act[0] = 1'b1;
    strobe.act[1] = (modeQ != MODE_ONE);
    strobe.act[2] = (modeQ == MODE_THREE);
  end

  a_r2_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt < perQ);
  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (cnt == perQ - 1'b1) |=> (cnt == '0));
  a_r2_min_period: assert property (@(posedge clk) disable iff (rst)
    perQ >= MIN_P);
endmodule

// File: rtl/mpwm_dp.sv
module mpwm_dp
  import mpwm_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int SENSE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  seqStrobe_t                  strobe,
  input  logic [CNT_W-1:0]            cnt,
  input  logic [CNT_W-1:0]            perQ,
  input  logic [CNT_W-1:0]            thirdQ,
  input  logic [CNT_W-1:0]            sixthQ,
  input  logic [NPH-1:0][CNT_W-1:0]   phaseOff,
  input  logic [CNT_W-1:0]            loopCmd,
  input  logic [NPH-1:0][CNT_W-1:0]   phaseCorr,
  input  logic [NPH-1:0][SENSE_W-1:0] senseIn,
  output logic [NPH-1:0]              pwmOut,
  output logic [NPH-1:0]              sampleWin,
  output logic [NPH-1:0][SENSE_W-1:0] heldSense
);
  for (genvar k = 0; k < NPH; k++) begin : g_phase
    logic [CNT_W-1:0]   ramp;
    logic [CNT_W-1:0]   thr;
    logic [CNT_W:0]     reach;
    logic               pastOff;
    logic               latchQ;
    logic               sampQ;
    logic [SENSE_W-1:0] trackQ;
    logic               live;

    assign live    = strobe.run && strobe.act[k];
    assign ramp    = (cnt >= phaseOff[k]) ? (cnt - phaseOff[k])
                                          : (cnt - phaseOff[k] + perQ);
    assign thr     = (loopCmd > phaseCorr[k]) ? (loopCmd - phaseCorr[k]) : '0;
    assign reach   = {1'b0, ramp} + {1'b0, thr};
    assign pastOff = (ramp >= thirdQ);

    assign pwmOut[k]    = live && pastOff && (latchQ || (reach >= {1'b0, perQ}));
    assign sampleWin[k] = live && (ramp >= sixthQ) && !pwmOut[k];

    always_ff @(posedge clk) begin
      if (rst) begin
        latchQ       <= 1'b0;
        sampQ        <= 1'b0;
        trackQ       <= '0;
        heldSense[k] <= '0;
      end else begin
        latchQ <= pwmOut[k];
        sampQ  <= sampleWin[k];
        if (sampleWin[k])          trackQ       <= senseIn[k];
        if (sampQ && !sampleWin[k]) heldSense[k] <= trackQ;
      end
    end

    a_r6_min_off: assert property (@(posedge clk) disable iff (rst)
      ($fell(pwmOut[k]) && !strobe.fresh) |=> !pwmOut[k]);
    a_r5_idle_phase: assert property (@(posedge clk) disable iff (rst)
      !strobe.act[k] |-> (!pwmOut[k] && !sampleWin[k]));
    a_r8_window_excl: assert property (@(posedge clk) disable iff (rst)
      !(pwmOut[k] && sampleWin[k]));
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
      !(sampQ && !sampleWin[k]) |=> $stable(heldSense[k]));
  end

  a_r2_phase1_low_at_start: assert property (@(posedge clk) disable iff (rst)
    strobe.fresh |-> !pwmOut[0]);
endmodule

// File: rtl/mpwm_seq.sv
module mpwm_seq
  import mpwm_pkg::*;
#(
  parameter int CNT_W      = 10,
  parameter int SENSE_W    = 8,
  parameter int MIN_PERIOD = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CNT_W-1:0]            periodLen,
  input  logic [1:0]                  phasePresent,
  input  logic [CNT_W-1:0]            loopCmd,
  input  logic [NPH-1:0][CNT_W-1:0]   phaseCorr,
  input  logic [NPH-1:0][SENSE_W-1:0] senseIn,
  output logic [NPH-1:0]              pwmOut,
  output logic [NPH-1:0]              sampleWin,
  output logic [NPH-1:0][SENSE_W-1:0] heldSense
);
  logic [CNT_W-1:0]          cnt;
  logic [CNT_W-1:0]          perQ;
  logic [CNT_W-1:0]          thirdQ;
  logic [CNT_W-1:0]          sixthQ;
  logic [NPH-1:0][CNT_W-1:0] phaseOff;
  seqStrobe_t                strobe;

  mpwm_ctrl #(.CNT_W(CNT_W), .MIN_PERIOD(MIN_PERIOD)) u_ctrl (
    .clk(clk), .rst(rst), .periodLen(periodLen), .phasePresent(phasePresent),
    .cnt(cnt), .perQ(perQ), .thirdQ(thirdQ), .sixthQ(sixthQ),
    .phaseOff(phaseOff), .strobe(strobe)
  );

  mpwm_dp #(.CNT_W(CNT_W), .SENSE_W(SENSE_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .cnt(cnt), .perQ(perQ),
    .thirdQ(thirdQ), .sixthQ(sixthQ), .phaseOff(phaseOff),
    .loopCmd(loopCmd), .phaseCorr(phaseCorr), .senseIn(senseIn),
    .pwmOut(pwmOut), .sampleWin(sampleWin), .heldSense(heldSense)
  );
endmodule

// File: tb/sim_mpwm_seq.sv
module sim_mpwm_seq;
  localparam int W  = 10;
  localparam int SW = 8;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [W-1:0]        periodLen = W'(30);
  logic [1:0]          pres = 2'b11;
  logic [W-1:0]        cmd = '0;
  logic [2:0][W-1:0]   corr = '0;
  logic [2:0][SW-1:0]  sense = '0;
  logic [2:0]          pwmOut;
  logic [2:0]          sampleWin;
  logic [2:0][SW-1:0]  heldSense;

  mpwm_seq #(.CNT_W(W), .SENSE_W(SW), .MIN_PERIOD(6)) u0 (
    .clk(clk), .rst(rst), .periodLen(periodLen), .phasePresent(pres),
    .loopCmd(cmd), .phaseCorr(corr), .senseIn(sense),
    .pwmOut(pwmOut), .sampleWin(sampleWin), .heldSense(heldSense)
  );

  always #10ns clk = ~clk;

  int nChecks = 0;
  int nErr = 0;
  bit done = 0;
  bit primed = 0;
  int cyc = 0;

  int mCnt, mP, mT, mH, mS, mMode;
  bit mLatch[3];
  bit mSampQ[3];
  int mTrack[3];
  int mHeld[3];

  bit prevPwm[3];
  int lastFall[3];
  int fallGap[3];
  int highCnt[3];
  int winCnt[3];

  function automatic int offOf(int k);
    if (k == 0) return 0;
    if (k == 1) return (mMode == 3) ? mT : mH;
    return 2 * mT;
  endfunction

  function automatic bit actOf(int k);
    return (k == 0) || (k == 1 && mMode >= 2) || (k == 2 && mMode == 3);
  endfunction

  function automatic int rampOf(int k);
    int o;
    o = offOf(k);
    return (mCnt >= o) ? (mCnt - o) : (mCnt + mP - o);
  endfunction

  function automatic bit expPwm(int k);
    int r, thr;
    if (rst || !actOf(k)) return 1'b0;
    r = rampOf(k);
    thr = (int'(cmd) > int'(corr[k])) ? int'(cmd) - int'(corr[k]) : 0;
    return (r >= mT) && (mLatch[k] || (r + thr >= mP));
  endfunction

  function automatic bit expWin(int k);
    if (rst || !actOf(k)) return 1'b0;
    return (rampOf(k) >= mS) && !expPwm(k);
  endfunction

  function automatic void loadParams();
    int p;
    p = (int'(periodLen) < 6) ? 6 : int'(periodLen);
    mP = p; mT = p / 3; mH = p / 2; mS = p / 6;
    mMode = !pres[0] ? 1 : (!pres[1] ? 2 : 3);
  endfunction

  function automatic void modelStep();
    bit pw[3];
    bit w[3];
    cyc++;
    if (rst) begin
      mCnt = 0;
      loadParams();
      for (int k = 0; k < 3; k++) begin
        mLatch[k] = 0; mSampQ[k] = 0; mTrack[k] = 0; mHeld[k] = 0;
      end
    end else begin
      for (int k = 0; k < 3; k++) begin
        pw[k] = expPwm(k);
        w[k] = expWin(k);
      end
      for (int k = 0; k < 3; k++) begin
        if (mSampQ[k] && !w[k]) mHeld[k] = mTrack[k];
        if (w[k]) mTrack[k] = int'(sense[k]);
        mSampQ[k] = w[k];
        mLatch[k] = pw[k];
      end
      if (mCnt == mP - 1) begin
        mCnt = 0;
        loadParams();
      end else begin
        mCnt++;
      end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic checkAll();
    bit ep, ew;
    for (int k = 0; k < 3; k++) begin
      if (primed) begin
        ep = expPwm(k);
        ew = expWin(k);
        if (rst) begin
          chk(pwmOut[k] == 1'b0, "R1 pwm in reset", int'(pwmOut[k]), 0);
          chk(sampleWin[k] == 1'b0, "R1 window in reset", int'(sampleWin[k]), 0);
        end else if (!actOf(k)) begin
          chk(pwmOut[k] == 1'b0 && sampleWin[k] == 1'b0, "R5 inactive phase outputs",
              int'({pwmOut[k], sampleWin[k]}), 0);
        end else begin
          chk(pwmOut[k] == ep, "R6/R7 pwm level", int'(pwmOut[k]), int'(ep));
          chk(sampleWin[k] == ew, "R8 sample window", int'(sampleWin[k]), int'(ew));
        end
        chk(int'(heldSense[k]) == mHeld[k], "R9 held sense", int'(heldSense[k]), mHeld[k]);
      end
      if (prevPwm[k] && !pwmOut[k]) begin
        fallGap[k] = cyc - lastFall[k];
        lastFall[k] = cyc;
      end
      prevPwm[k] = pwmOut[k];
      if (pwmOut[k]) highCnt[k]++;
      if (sampleWin[k]) winCnt[k]++;
    end
  endtask

  task automatic runCycle();
    #2ns;
    checkAll();
    @(posedge clk);
    modelStep();
    primed = 1;
    @(negedge clk);
  endtask

  task automatic scen(input int p, input bit [1:0] pr, input int c, input int n);
    rst = 1'b1;
    periodLen = W'(p);
    pres = pr;
    cmd = W'(c);
    corr = '0;
    runCycle();
    runCycle();
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      highCnt[k] = 0; winCnt[k] = 0; lastFall[k] = 0; fallGap[k] = 0; prevPwm[k] = 0;
    end
    for (int i = 0; i < n; i++) runCycle();
  endtask

  function automatic int modp(int a, int p);
    return ((a % p) + p) % p;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);

    // R1: outputs low and held values cleared under reset
    rst = 1'b1;
    runCycle();
    runCycle();
    chk(pwmOut == 3'b000, "R1 pwm after reset edge", int'(pwmOut), 0);
    chk(heldSense == '0, "R1 held cleared", int'(heldSense[0]), 0);

    // R3 and R6: three phases, command saturated
    scen(30, 2'b11, 1000, 90);
    chk(fallGap[0] == 30, "R2 phase1 fall spacing", fallGap[0], 30);
    chk(modp(lastFall[1] - lastFall[0], 30) == 10, "R3 phase2 stagger",
        modp(lastFall[1] - lastFall[0], 30), 10);
    chk(modp(lastFall[2] - lastFall[1], 30) == 10, "R3 phase3 stagger",
        modp(lastFall[2] - lastFall[1], 30), 10);
    chk(highCnt[0] == 60, "R6 forced off limits duty", highCnt[0], 60);

    // R4: two phases, odd period
    scen(31, 2'b01, 1000, 93);
    chk(modp(lastFall[1] - lastFall[0], 31) == 15, "R4 phase2 half stagger",
        modp(lastFall[1] - lastFall[0], 31), 15);
    chk(highCnt[2] == 0 && winCnt[2] == 0, "R5 phase3 idle in two-phase mode",
        highCnt[2] + winCnt[2], 0);

    // R5: single phase for both encodings without phase 2
    scen(24, 2'b00, 1000, 48);
    chk(highCnt[1] + highCnt[2] + winCnt[1] + winCnt[2] == 0, "R5 single phase mode 00",
        highCnt[1] + highCnt[2], 0);
    scen(24, 2'b10, 1000, 48);
    chk(highCnt[1] + highCnt[2] + winCnt[1] + winCnt[2] == 0, "R5 single phase mode 10",
        highCnt[1] + highCnt[2], 0);

    // R2: period below minimum clamps to 6
    scen(2, 2'b11, 1000, 30);
    chk(fallGap[0] == 6, "R2 period clamp", fallGap[0], 6);

    // R7 and R8: zero command never turns on, window spans rest of period
    scen(30, 2'b11, 0, 90);
    chk(highCnt[0] == 0, "R7 zero command stays low", highCnt[0], 0);
    chk(winCnt[0] == 75, "R8 window length", winCnt[0], 75);

    // R7: mid command gives on-time equal to threshold
    scen(30, 2'b11, 12, 90);
    chk(highCnt[0] == 36, "R7 on-time from threshold", highCnt[0], 36);

    // Random mix, checked every cycle against the model
    for (int blk = 0; blk < 40; blk++) begin
      periodLen = W'(3 + ($urandom % 68));
      pres = 2'($urandom);
      rst = (($urandom % 4) == 0) ? 1'b1 : 1'b0;
      if (rst) runCycle();
      rst = 1'b0;
      for (int i = 0; i < 60; i++) begin
        cmd = W'($urandom % 80);
        for (int k = 0; k < 3; k++) begin
          corr[k] = W'($urandom % 20);
          sense[k] = SW'($urandom);
        end
        runCycle();
      end
    end

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end

  initial begin
    #2ms;
    if (!done) begin
      done = 1;
      nChecks++;
      nErr++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule